// File: doc/BRIEF.md
# Wait and Stop Power Controller

This block decides when a processor core may run, when it must stall and when its clock must be switched off. A one-cycle wait strobe from the instruction sequencer drops the ready output so the core stalls until an interrupt arrives. A one-cycle stop strobe drops the clock-enable output, and after that only a falling edge on the reset line brings the clock back.

Wake and interrupt requests follow a fixed priority: reset, then abort, then NMI, then IRQ. The chosen action is shown on a one-hot output and held there until the core acknowledges it. A masked IRQ arriving during a wait does not enter a handler. It only lets the core continue with the instruction after the wait. An abort taken during a wait leaves the core stalled. Whatever interrupt ends that stall is flagged so that the core returns to the wait instruction.

The action output is one-hot. Bit 0 means reset, bit 1 abort, bit 2 NMI, bit 3 IRQ handler, and bit 4 means resume without a handler. All request inputs are active low. NMI, abort and reset are taken on their falling edge. IRQ is a level. `rst_n` is the synchronous initialisation of the block's own flops.

Top module: `wait_stop_ctl`

## Requirements
- R1: After `rst_n` the block is running: `rdy`=1, `clk_en`=1, `act`=0, `ret_wai`=0.
- R2: A `wai_exec` strobe with no action outstanding drops `rdy` to 0 from the next clock edge, while `clk_en` stays 1 and `act` stays 0 until a wake request arrives.
- R3: A falling edge on `nmi_n` raises `act`=5'b00100 at the next edge, in both run and wait. Holding `nmi_n` low yields only one NMI action.
- R4: A low `irq_n` with `i_flag`=0 raises `act`=5'b01000. With `i_flag`=1 it is ignored while running. During a wait it instead raises `act`=5'b10000 (resume, no handler), and `rdy` returns to 1 in either wake case.
- R5: An `abort_n` falling edge during a wait raises `act`=5'b00010 while `rdy` stays 0 even after acknowledge. The interrupt that later ends this stall raises its action with `ret_wai`=1.
- R6: When several requests are present at once, the action loaded is the highest of reset > abort > NMI > IRQ, so NMI beats IRQ in the same cycle.
- R7: A `stp_exec` strobe drops `clk_en` and `rdy` to 0 at the next edge. NMI, IRQ and abort activity while stopped produces no action, neither then nor after restart.
- R8: In the stopped state a falling edge on `res_n` raises `clk_en` in the same cycle. At the next edge `act`=5'b00001 and `rdy`=1.
- R9: A loaded action stays stable until `ack`. `act` is 0 after the acknowledging edge, and a request that arrived meanwhile loads at the following edge.
- R10: A reset request replaces any other outstanding action at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous initialisation, active low |
| wai_exec | input | 1 | One-cycle strobe: wait instruction executed |
| stp_exec | input | 1 | One-cycle strobe: stop instruction executed |
| res_n | input | 1 | Core reset request, active low, falling edge taken |
| abort_n | input | 1 | Abort request, active low, falling edge taken |
| nmi_n | input | 1 | Non-maskable interrupt, active low, falling edge taken |
| irq_n | input | 1 | Maskable interrupt, active low level |
| i_flag | input | 1 | IRQ disable flag from the status register |
| ack | input | 1 | Core has taken the current action |
| rdy | output | 1 | Core may advance (low during wait, aborted wait, stop) |
| clk_en | output | 1 | Core clock enable (low while stopped) |
| act | output | 5 | One-hot action: reset, abort, NMI, IRQ, resume |
| ret_wai | output | 1 | Action must return to the wait instruction |

## Verification
A wrong state register shows up within one edge of the next strobe or request. `rdy` or `clk_en` will carry the wrong level, or `act` will load the wrong one-hot code, or none, for that request. A lost or stuck pending flag shows up when a request fails to appear, or appears twice, right after an acknowledge. Priority errors show up at once: every subset of simultaneous requests is swept and the loaded code is compared with the highest member of the subset.

// File: rtl/wait_stop_ctl.sv
module wait_stop_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wai_exec,
  input  logic       stp_exec,
  input  logic       res_n,
  input  logic       abort_n,
  input  logic       nmi_n,
  input  logic       irq_n,
  input  logic       i_flag,
  input  logic       ack,
  output logic       rdy,
  output logic       clk_en,
  output logic [4:0] act,
  output logic       ret_wai
);

  localparam logic [4:0] A_RES = 5'b00001;
  localparam logic [4:0] A_ABT = 5'b00010;
  localparam logic [4:0] A_NMI = 5'b00100;
  localparam logic [4:0] A_IRQ = 5'b01000;
  localparam logic [4:0] A_RSM = 5'b10000;

  typedef enum logic [1:0] {S_RUN, S_WAIT, S_ABWT, S_STOP} st_t;

  st_t        st, st_nx;
  logic       res_q, abt_q, nmi_q;
  logic       res_p, abt_p, nmi_p;
  logic [4:0] act_q, ld_act;
  logic       rw_q, ld_rw, ld;

  wire live     = (st != S_STOP);
  wire res_fall = res_q & ~res_n;
  wire abt_fall = live & abt_q & ~abort_n;
  wire nmi_fall = live & nmi_q & ~nmi_n;
  wire res_req  = res_p | res_fall;
  wire abt_req  = abt_p | abt_fall;
  wire nmi_req  = nmi_p | nmi_fall;
  wire irq_on   = live & ~irq_n;
  wire free     = (act_q == 5'd0);

  always_comb begin
    st_nx  = st;
    ld     = 1'b0;
    ld_act = 5'd0;
    ld_rw  = 1'b0;
    if (res_req && !act_q[0]) begin
      ld = 1'b1; ld_act = A_RES; st_nx = S_RUN;
    end else if (free && live) begin
      case (st)
        S_RUN: begin
          if (abt_req)                begin ld = 1'b1; ld_act = A_ABT; end
          else if (nmi_req)           begin ld = 1'b1; ld_act = A_NMI; end
          else if (irq_on && !i_flag) begin ld = 1'b1; ld_act = A_IRQ; end
          else if (stp_exec)          st_nx = S_STOP;
          else if (wai_exec)          st_nx = S_WAIT;
        end
        S_WAIT: begin
          if (abt_req)     begin ld = 1'b1; ld_act = A_ABT; st_nx = S_ABWT; end
          else if (nmi_req) begin ld = 1'b1; ld_act = A_NMI; st_nx = S_RUN; end
          else if (irq_on) begin
            ld = 1'b1; ld_act = i_flag ? A_RSM : A_IRQ; st_nx = S_RUN;
          end
        end
        S_ABWT: begin
          if (abt_req)      begin ld = 1'b1; ld_act = A_ABT; end
          else if (nmi_req) begin ld = 1'b1; ld_act = A_NMI; ld_rw = 1'b1; st_nx = S_RUN; end
          else if (irq_on) begin
            ld = 1'b1; ld_act = i_flag ? A_RSM : A_IRQ; ld_rw = 1'b1; st_nx = S_RUN;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_RUN;
      res_q <= 1'b1;
      abt_q <= 1'b1;
      nmi_q <= 1'b1;
      res_p <= 1'b0;
      abt_p <= 1'b0;
      nmi_p <= 1'b0;
      act_q <= 5'd0;
      rw_q  <= 1'b0;
    end else begin
      st    <= st_nx;
      res_q <= res_n;
      abt_q <= abort_n;
      nmi_q <= nmi_n;
      res_p <= res_req & ~(ld & ld_act[0]);
      abt_p <= abt_req & ~(ld & (ld_act[0] | ld_act[1]));
      nmi_p <= nmi_req & ~(ld & (ld_act[0] | ld_act[2]));
      if (ld) begin
        act_q <= ld_act;
        rw_q  <= ld_rw;
      end else if (ack) begin
        act_q <= 5'd0;
        rw_q  <= 1'b0;
      end
    end
  end

  assign rdy     = (st == S_RUN);
  assign clk_en  = live | res_fall;
  assign act     = act_q;
  assign ret_wai = rw_q;

  p_act_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act));

  p_act_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (act != 5'd0 && !ack && !res_fall) |=> $stable(act));

  p_reset_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_fall |=> act == A_RES);

  p_stop_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> act == 5'd0);

  p_wait_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && act == 5'd0 && wai_exec && !stp_exec && res_n && abort_n && nmi_n
     && (irq_n || i_flag)) |=> !rdy);

  p_retwai_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ret_wai |-> act != 5'd0);

endmodule

// File: tb/sim_wait_stop_ctl.sv
`timescale 1ns/1ps
module sim_wait_stop_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wai_exec = 0, stp_exec = 0, res_n = 1, abort_n = 1, nmi_n = 1, irq_n = 1;
  logic i_flag = 0, ack = 0;
  logic rdy, clk_en, ret_wai;
  logic [4:0] act;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wait_stop_ctl u0 (.clk(clk), .rst_n(rst_n), .wai_exec(wai_exec), .stp_exec(stp_exec),
    .res_n(res_n), .abort_n(abort_n), .nmi_n(nmi_n), .irq_n(irq_n), .i_flag(i_flag),
    .ack(ack), .rdy(rdy), .clk_en(clk_en), .act(act), .ret_wai(ret_wai));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [4:0] got, input logic [4:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  task automatic idle_in();
    wai_exec = 0; stp_exec = 0; res_n = 1; abort_n = 1; nmi_n = 1; irq_n = 1; ack = 0;
  endtask

  task automatic restart(input logic ifl);
    idle_in(); i_flag = ifl; rst_n = 0; step(1); rst_n = 1; step(1);
  endtask

  task automatic do_ack();
    ack = 1; step(1); ack = 0;
  endtask

  task automatic enter_wait();
    wai_exec = 1; step(1); wai_exec = 0;
  endtask

  initial begin
    step(2); rst_n = 1; step(1);
    chk("R1 rdy", {4'd0, rdy}, 5'd1);
    chk("R1 clk_en", {4'd0, clk_en}, 5'd1);
    chk("R1 act", act, 5'd0);
    chk("R1 ret_wai", {4'd0, ret_wai}, 5'd0);

    // R2 R3 R4: sweep of nmi/irq/mask during wait
    for (int v = 0; v < 8; v++) begin
      logic [4:0] e;
      restart(v[2]);
      enter_wait();
      if (v == 0) begin
        chk("R2 rdy", {4'd0, rdy}, 5'd0);
        chk("R2 clk_en", {4'd0, clk_en}, 5'd1);
      end
      nmi_n = ~v[0]; irq_n = ~v[1];
      step(1);
      e = v[0] ? 5'b00100 : (v[1] ? (v[2] ? 5'b10000 : 5'b01000) : 5'd0);
      chk(v[0] ? "R3 wake act" : "R4 wake act", act, e);
      chk("R4 wake rdy", {4'd0, rdy}, {4'd0, e != 5'd0});
    end

    // R6: every subset of simultaneous requests while running
    for (int v = 0; v < 16; v++) begin
      logic [4:0] e;
      restart(1'b0);
      res_n = ~v[3]; abort_n = ~v[2]; nmi_n = ~v[1]; irq_n = ~v[0];
      step(1);
      e = v[3] ? 5'b00001 : v[2] ? 5'b00010 : v[1] ? 5'b00100 : v[0] ? 5'b01000 : 5'd0;
      chk("R6 priority", act, e);
    end

    // R4: masked IRQ while running does nothing
    restart(1'b1); irq_n = 0; step(3);
    chk("R4 masked run", act, 5'd0);
    chk("R4 masked run rdy", {4'd0, rdy}, 5'd1);

    // R3: held NMI gives one action
    restart(1'b0); nmi_n = 0; step(1);
    chk("R3 nmi run", act, 5'b00100);
    do_ack();
    chk("R3 after ack", act, 5'd0);
    step(3);
    chk("R3 held low once", act, 5'd0);

    // R9: hold until ack, queued IRQ loads afterwards
    restart(1'b0); nmi_n = 0; irq_n = 0; step(1);
    chk("R9 nmi first", act, 5'b00100);
    step(2);
    chk("R9 held", act, 5'b00100);
    do_ack();
    chk("R9 cleared", act, 5'd0);
    step(1);
    chk("R9 queued irq", act, 5'b01000);

    // R10: reset replaces outstanding action
    restart(1'b0); irq_n = 0; step(1);
    chk("R10 irq", act, 5'b01000);
    res_n = 0; step(1);
    chk("R10 reset override", act, 5'b00001);

    // R5: abort during wait, then NMI returns to wait
    restart(1'b0); enter_wait();
    abort_n = 0; step(1); abort_n = 1;
    chk("R5 abort act", act, 5'b00010);
    chk("R5 abort rdy", {4'd0, rdy}, 5'd0);
    do_ack(); step(2);
    chk("R5 still stalled", {4'd0, rdy}, 5'd0);
    chk("R5 no action", act, 5'd0);
    nmi_n = 0; step(1);
    chk("R5 nmi act", act, 5'b00100);
    chk("R5 ret_wai", {4'd0, ret_wai}, 5'd1);
    chk("R5 rdy back", {4'd0, rdy}, 5'd1);

    restart(1'b1); enter_wait();
    abort_n = 0; step(1); abort_n = 1; do_ack();
    irq_n = 0; step(1);
    chk("R5 masked resume", act, 5'b10000);
    chk("R5 masked ret_wai", {4'd0, ret_wai}, 5'd1);

    // R7 R8: stop and restart
    restart(1'b0);
    stp_exec = 1; step(1); stp_exec = 0;
    chk("R7 clk_en off", {4'd0, clk_en}, 5'd0);
    chk("R7 rdy off", {4'd0, rdy}, 5'd0);
    nmi_n = 0; irq_n = 0; abort_n = 0; step(3);
    chk("R7 ignored act", act, 5'd0);
    chk("R7 still off", {4'd0, clk_en}, 5'd0);
    nmi_n = 1; irq_n = 1; abort_n = 1; step(1);
    res_n = 0; #1;
    chk("R8 clk_en same cycle", {4'd0, clk_en}, 5'd1);
    @(negedge clk);
    chk("R8 reset act", act, 5'b00001);
    chk("R8 rdy", {4'd0, rdy}, 5'd1);
    res_n = 1; do_ack(); step(2);
    chk("R7 nothing latched", act, 5'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog got=hang exp=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule